// File: doc/BRIEF.md
# Prescaled Reloading Wake-up Timer

The block is a free-running real-time timer meant to keep counting while the rest of the chip is idle. Its count is split in two stages: a 7-bit prescaler that divides the selected source ticks by 128, and a 16-bit down counter that software preloads. Each time the down counter has been stepped through zero, it is refilled from a reload register and a sticky expiry flag is raised. The flag can be routed to a wake request, an interrupt request, or both, through two separate enables.

The source of the count is chosen between a CPU-clock tick and a crystal-oscillator tick. Both are modelled as single-cycle clock enables in the one clock domain, not as a real clock mux. When a status input says the crystal is already driving the CPU, the block counts the CPU tick whatever the select says. Only the power-on reset returns the timer to its defaults. The ordinary system reset input is accepted but leaves the count, the reload value and the flag as they are.

Top module: `wake_timer`

## Requirements
- R1: While `por_n` is low at a clock edge, the prescaler becomes 127, the down counter and the reload register become 16'hFFFF, and the flag becomes 0.
- R2: Holding `sys_rst_n` low changes neither the prescaler, the down counter, the reload register nor the flag.
- R3: The counting tick is `xtal_tick` when `src_xtal`=1 and `xtal_is_cpu`=0, and `cpu_tick` otherwise. With `run`=0 no tick is counted.
- R4: The prescaler counts down by one per tick. On a tick while it is 0 it returns to 127 and steps the down counter once.
- R5: A step decrements the down counter. A step while it is 0 refills it from the reload register and sets the flag, so one period is (reload+1)×128 ticks.
- R6: A reload write (`reload_we`=1) while `run`=0 stores the value, loads it into the down counter at once and presets the prescaler to 127.
- R7: A reload write while `run`=1 only updates the reload register and takes effect at the next refill. A write in the same cycle as a refill is the value loaded.
- R8: The flag stays set until a cycle with `flag_clr`=1. When an expiry and a clear fall in the same cycle, the flag ends set.
- R9: `wake_o` equals flag AND `wake_en`. `irq_o` equals flag AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| sys_rst_n | input | 1 | Ordinary system reset, has no effect on the timer |
| cpu_tick | input | 1 | One-cycle tick of the CPU-clock source |
| xtal_tick | input | 1 | One-cycle tick of the crystal source |
| src_xtal | input | 1 | 1 selects the crystal source |
| xtal_is_cpu | input | 1 | 1 when the crystal is the CPU clock; forces the CPU source |
| run | input | 1 | Counting enable |
| reload_we | input | 1 | Write strobe for the reload value |
| reload_val | input | 16 | Reload value to write |
| flag_clr | input | 1 | Write-one-to-clear for the expiry flag |
| wake_en | input | 1 | Routes the flag to the wake request |
| irq_en | input | 1 | Routes the flag to the interrupt request |
| presc_o | output | 7 | Current prescaler value |
| count_o | output | 16 | Current down-counter value |
| flag_o | output | 1 | Sticky expiry flag |
| wake_o | output | 1 | Wake request |
| irq_o | output | 1 | Interrupt request |

## Verification
Two things can land in the same cycle. An expiry can meet a software clear of the flag, and a refill can meet a reload write while running. The first is forced directly: the down counter is loaded with 0 and `flag_clr` is held high for the whole 128-tick period. The flag must read 1 just after the expiry edge and 0 one cycle later. The second occurs in the random phase, where short reload values and frequent writes make the two collide often. There, a cycle-by-cycle bench model checks that the newly written value is the one that appears in the counter.

// File: rtl/wt_pkg.sv
// Package wt_pkg
// Shared sizes for the wake-up timer. Assumes the prescaler width and the
// counter width are set together here and passed down as parameters.
package wt_pkg;
    localparam int PRE_W = 7;
    localparam int CNT_W = 16;

    typedef enum logic {
        SRC_CPU  = 1'b0,
        SRC_XTAL = 1'b1
    } tick_src_e;
endpackage

// File: rtl/wt_tick_sel.sv
// Module wt_tick_sel
// Picks the counting tick from two clock-enable sources. Assumes both ticks
// are single-cycle enables in the block clock domain; the crystal source is
// refused while the crystal already drives the CPU.
module wt_tick_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_tick,
    input  logic xtal_tick,
    input  logic src_xtal,
    input  logic xtal_is_cpu,
    input  logic run,
    output logic tick
);
    import wt_pkg::*;

    tick_src_e src_eff;

    // Resolve the effective source, forcing CPU when the crystal is the CPU clock
    always_comb begin
        src_eff = (src_xtal && !xtal_is_cpu) ? SRC_XTAL : SRC_CPU;
    end

    // Gate the chosen tick with the run enable
    always_comb begin
        tick = run && ((src_eff == SRC_XTAL) ? xtal_tick : cpu_tick);
    end

    AST_XTAL_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (xtal_is_cpu && run) |-> (tick == cpu_tick)); // R3
    AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick); // R3
endmodule

// File: rtl/wt_prescaler.sv
// Module wt_prescaler
// Down-counting prescaler that wraps from zero to its maximum and emits a
// one-cycle step on each wrap. Assumes preset and tick never need to act
// together (preset is only raised while stopped).
module wt_prescaler #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         preset,
    output logic [W-1:0] presc,
    output logic         wrap
);
    localparam logic [W-1:0] PRE_MAX = {W{1'b1}};

    // Step request when a tick arrives at zero
    always_comb begin
        wrap = tick && (presc == '0);
    end

    // Prescaler register with power-on reset and preset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc <= PRE_MAX;
        end else if (preset) begin
            presc <= PRE_MAX;
        end else if (tick) begin
            presc <= presc - 1'b1;
        end
    end

    AST_PRESC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !preset && presc == '0) |=> (presc == PRE_MAX)); // R4
    AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !preset) |=> $stable(presc)); // R4
endmodule

// File: rtl/wt_down_counter.sv
// Module wt_down_counter
// Loadable down counter with a reload register. A step at zero refills from
// the reload value and pulses expire. Assumes load is only raised while the
// timer is stopped, so it never meets a step.
module wt_down_counter #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   INIT = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic         reload_we,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] cnt,
    output logic         expire
);
    logic [W-1:0] reload_q;
    logic [W-1:0] refill_val;
    logic         load;

    // Immediate load only when stopped; a same-cycle write feeds the refill
    always_comb begin
        load       = reload_we && !run;
        refill_val = reload_we ? reload_val : reload_q;
        expire     = step && (cnt == '0);
    end

    // Reload register holding the software value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= INIT;
        end else if (reload_we) begin
            reload_q <= reload_val;
        end
    end

    // Counter register: immediate load, refill at zero, else decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= INIT;
        end else if (load) begin
            cnt <= reload_val;
        end else if (step) begin
            cnt <= (cnt == '0) ? refill_val : cnt - 1'b1;
        end
    end

    AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R5
    AST_CNT_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !reload_we && cnt == '0) |=> (cnt == $past(reload_q))); // R5
    AST_LOAD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(reload_val))); // R6
    AST_WRITE_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && reload_we && !step) |=> $stable(cnt)); // R7
endmodule

// File: rtl/wt_flag.sv
// Module wt_flag
// Sticky expiry flag with write-one-to-clear. Assumes set and clear can
// coincide; set wins so no expiry is lost.
module wt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Flag register: set dominates clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R8
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag); // R8
endmodule

// File: rtl/wake_timer.sv
// Module wake_timer
// Real-time wake-up timer: source select, 128-way prescaler, reloading
// 16-bit down counter and sticky flag routed to wake and interrupt requests.
// Assumes all ticks are clock enables of clk. Only por_n resets the state;
// sys_rst_n is deliberately not connected to any register.
module wake_timer #(
    parameter int PRE_W = wt_pkg::PRE_W,
    parameter int CNT_W = wt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             cpu_tick,
    input  logic             xtal_tick,
    input  logic             src_xtal,
    input  logic             xtal_is_cpu,
    input  logic             run,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             flag_clr,
    input  logic             wake_en,
    input  logic             irq_en,
    output logic [PRE_W-1:0] presc_o,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             wake_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] CNT_INIT = {CNT_W{1'b1}};

    logic tick;
    logic step;
    logic expire;
    logic preset;

    // Prescaler preset accompanies an immediate load while stopped
    always_comb begin
        preset = reload_we && !run;
    end

    wt_tick_sel u_sel (
        .clk        (clk),
        .rst_n      (por_n),
        .cpu_tick   (cpu_tick),
        .xtal_tick  (xtal_tick),
        .src_xtal   (src_xtal),
        .xtal_is_cpu(xtal_is_cpu),
        .run        (run),
        .tick       (tick)
    );

    wt_prescaler #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (por_n),
        .tick  (tick),
        .preset(preset),
        .presc (presc_o),
        .wrap  (step)
    );

    wt_down_counter #(.W(CNT_W), .INIT(CNT_INIT)) u_cnt (
        .clk       (clk),
        .rst_n     (por_n),
        .run       (run),
        .step      (step),
        .reload_we (reload_we),
        .reload_val(reload_val),
        .cnt       (count_o),
        .expire    (expire)
    );

    wt_flag u_flag (
        .clk  (clk),
        .rst_n(por_n),
        .set  (expire),
        .clr  (flag_clr),
        .flag (flag_o)
    );

    // Route the flag to the two request outputs
    always_comb begin
        wake_o = flag_o && wake_en;
        irq_o  = flag_o && irq_en;
    end

    AST_SYSRST_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && !tick && !reload_we && !flag_clr)
        |=> ($stable(count_o) && $stable(presc_o) && $stable(flag_o))); // R2
    AST_WAKE_GATE: assert property (@(posedge clk) disable iff (!por_n)
        wake_o |-> (flag_o && wake_en)); // R9
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!por_n)
        irq_o |-> (flag_o && irq_en)); // R9
endmodule

// File: tb/wake_timer_tb_top.sv
`timescale 1ns/1ps
// Bench for wake_timer: directed corner cases followed by seeded random
// stimulus, all compared against a bench model built from the requirements.
module wake_timer_tb_top;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        cpu_tick = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        src_xtal = 1'b0;
    logic        xtal_is_cpu = 1'b0;
    logic        run = 1'b0;
    logic        reload_we = 1'b0;
    logic [15:0] reload_val = 16'h0;
    logic        flag_clr = 1'b0;
    logic        wake_en = 1'b0;
    logic        irq_en = 1'b0;
    logic [6:0]  presc_o;
    logic [15:0] count_o;
    logic        flag_o;
    logic        wake_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    // Bench model state
    logic [6:0]  m_p = 7'd127;
    logic [15:0] m_c = 16'hFFFF;
    logic [15:0] m_r = 16'hFFFF;
    logic        m_f = 1'b0;

    always #2.5 clk = ~clk;

    wake_timer dut_i (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .cpu_tick(cpu_tick), .xtal_tick(xtal_tick), .src_xtal(src_xtal),
        .xtal_is_cpu(xtal_is_cpu), .run(run), .reload_we(reload_we),
        .reload_val(reload_val), .flag_clr(flag_clr), .wake_en(wake_en),
        .irq_en(irq_en), .presc_o(presc_o), .count_o(count_o),
        .flag_o(flag_o), .wake_o(wake_o), .irq_o(irq_o)
    );

    function automatic logic eff_tick(logic r, logic sx, logic xc, logic ct, logic xt);
        return r && ((sx && !xc) ? xt : ct);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Model update from the requirements, one step per clock edge
    always @(posedge clk) begin
        logic t;
        logic [15:0] nr;
        cycles++;
        if (!por_n) begin
            m_p = 7'd127; m_c = 16'hFFFF; m_r = 16'hFFFF; m_f = 1'b0;   // R1
        end else begin
            t  = eff_tick(run, src_xtal, xtal_is_cpu, cpu_tick, xtal_tick);
            nr = reload_we ? reload_val : m_r;
            if (reload_we && !run) begin
                m_c = reload_val; m_p = 7'd127;                          // R6
                m_f = flag_clr ? 1'b0 : m_f;
            end else if (t && m_p == 7'd0) begin
                m_p = 7'd127;
                if (m_c == 16'd0) begin
                    m_c = nr; m_f = 1'b1;                                // R5 R7 R8
                end else begin
                    m_c = m_c - 16'd1;
                    m_f = flag_clr ? 1'b0 : m_f;
                end
            end else begin
                if (t) m_p = m_p - 7'd1;                                 // R4
                m_f = flag_clr ? 1'b0 : m_f;
            end
            m_r = nr;
        end
    end

    // Continuous comparison against the model away from the active edge
    always @(negedge clk) begin
        if (model_on && !done) begin
            check("R4 presc", presc_o, m_p);
            check("R5 count", count_o, m_c);
            check("R8 flag", flag_o, m_f);
            check("R9 wake", wake_o, m_f && wake_en);
            check("R9 irq", irq_o, m_f && irq_en);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 190000);
            finish_run();
        end
    end

    task automatic stopped_load(logic [15:0] v);
        @(negedge clk);
        run = 1'b0; reload_we = 1'b1; reload_val = v; flag_clr = 1'b1;
        @(negedge clk);
        reload_we = 1'b0; flag_clr = 1'b0;
    endtask

    initial begin
        int n;
        void'($urandom(32'h5EED_2024));
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        check("R1 presc reset", presc_o, 127);
        check("R1 count reset", count_o, 16'hFFFF);
        check("R1 flag reset", flag_o, 0);

        // R6: stopped load, then R2: system reset leaves state alone
        stopped_load(16'd5);
        check("R6 load count", count_o, 5);
        check("R6 load presc", presc_o, 127);
        sys_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 count kept", count_o, 5);
        sys_rst_n = 1'b1;

        // R3: crystal select refused when crystal is the CPU clock
        src_xtal = 1'b1; xtal_is_cpu = 1'b1; cpu_tick = 1'b1; xtal_tick = 1'b0; run = 1'b1;
        repeat (10) @(negedge clk);
        check("R3 override counts cpu", presc_o, 117);
        xtal_is_cpu = 1'b0;
        repeat (10) @(negedge clk);
        check("R3 xtal idle holds", presc_o, 117);
        run = 1'b0; src_xtal = 1'b0;

        // R5: period of (2+1)*128 ticks
        stopped_load(16'd2);
        run = 1'b1; cpu_tick = 1'b1;
        n = 0;
        while (!flag_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check("R5 period", n, 384);
        check("R5 refill", count_o, 2);

        // R9: request routing
        wake_en = 1'b1; irq_en = 1'b0;
        #0.1;
        check("R9 wake on", wake_o, 1);
        check("R9 irq off", irq_o, 0);
        wake_en = 1'b0; irq_en = 1'b1;
        #0.1;
        check("R9 wake off", wake_o, 0);
        check("R9 irq on", irq_o, 1);
        run = 1'b0;

        // R8: clear held through an expiry, set wins at the collision
        stopped_load(16'd0);
        run = 1'b1; cpu_tick = 1'b1; flag_clr = 1'b1;
        repeat (128) @(negedge clk);
        check("R8 set beats clear", flag_o, 1);
        @(negedge clk);
        check("R8 clear after", flag_o, 0);
        flag_clr = 1'b0; run = 1'b0;

        // R7: write while running is deferred to the refill
        stopped_load(16'd0);
        run = 1'b1;
        repeat (50) @(negedge clk);
        reload_we = 1'b1; reload_val = 16'd3;
        @(negedge clk);
        reload_we = 1'b0;
        check("R7 write deferred", count_o, 0);
        repeat (77) @(negedge clk);
        check("R7 new reload used", count_o, 3);
        check("R7 flag at refill", flag_o, 1);

        // Random phase
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            cpu_tick    = ($urandom % 4) != 0;
            xtal_tick   = ($urandom % 3) == 0;
            src_xtal    = ($urandom % 8) < 3;
            xtal_is_cpu = ($urandom % 8) == 0;
            run         = ($urandom % 64) != 0;
            reload_we   = ($urandom % 40) == 0;
            reload_val  = 16'($urandom % 8);
            flag_clr    = ($urandom % 30) == 0;
            wake_en     = $urandom % 2;
            irq_en      = $urandom % 2;
            sys_rst_n   = ($urandom % 16) != 0;
            por_n       = ($urandom % 3000) != 0;
        end
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule